// File: doc/BRIEF.md
# Masked Compare-Driven Port Register

This block owns an 8-bit output port register and two 8-bit control registers, an enable mask and a drive-data register. They sit on a small byte-wide register bus. When a timer comparator elsewhere signals a match, the block loads each port bit whose mask bit is set with the matching bit of the drive-data register. Every other port bit keeps its current value. One compare event can therefore set, clear or leave alone any group of pins at the same time.

Only bit positions 7 down to 3 of the mask and drive-data registers are built. Bits 2 down to 0 always read as zero and cannot be written. Software can also write the port register directly. When a software write and a match land on the same clock edge, the masked bits take the compare data and the other bits take the written byte. The counter, the comparator, prescaling and interrupt flags all live outside this block.

Top module: `cmpport_top`

## Requirements
- R1: After synchronous reset, the mask, drive-data and port registers and the read data output are all zero.
- R2: A write to the mask register (address 0) or the drive-data register (address 1) stores bits 7..3 only. Bits 2..0 read back as zero whatever was written, and they never influence the port.
- R3: On the clock edge where `cmp_match` is high, each port bit whose mask bit is 1 takes the value of the matching drive-data bit.
- R4: On a compare, each port bit whose mask bit is 0 keeps its previous value.
- R5: A write to the port register (address 2) with no compare loads all 8 bits of the written byte into the port.
- R6: When a port write and a compare fall on the same edge, masked bits take the drive-data bit and unmasked bits take the written byte.
- R7: The port changes only on an edge where `cmp_match` is high or a port write occurs, and the new value is visible after that edge. Otherwise the port holds.
- R8: Reads are registered. `rd_data` loads the addressed register on an edge where `rd_en` is high and holds its value while `rd_en` is low. Address 2 returns the port, and address 3 returns zero.
- R9: A compare on the same edge as a mask or drive-data write uses the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register select: 0 mask, 1 drive data, 2 port, 3 unused |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| cmp_match | input | 1 | One-cycle compare match pulse |
| port_out | output | 8 | Port register value |

## Verification
The bench steps through every one of the 32 implemented mask values crossed with all 32 implemented drive-data values. Before each compare it presets the port to a pattern derived from both values. As a result, each bit position is covered as masked-and-set, masked-and-clear and unmasked against both starting levels, which separates a correct merge from one that inverts, ignores or swaps the mask. Separate cases cover writes to the low bits, a port write that coincides with a compare, a compare on the same edge as a mask write, idle cycles, and the read-hold and unused-address read paths.

// File: rtl/cmpport_pkg.sv
package cmpport_pkg;

    localparam int DATA_W   = 8;
    localparam int LOW_IMPL = 3;
    localparam int ADDR_W   = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_MASK = 2'd0,
        ADR_DRV  = 2'd1,
        ADR_PORT = 2'd2,
        ADR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        reg_addr_e         addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    // Merge compare data into a base value under a mask.
    function automatic logic [DATA_W-1:0] mask_merge(
        input logic [DATA_W-1:0] msk,
        input logic [DATA_W-1:0] drv,
        input logic [DATA_W-1:0] base
    );
        return (msk & drv) | (~msk & base);
    endfunction

endpackage

// File: rtl/cmpport_ctl_regs.sv
module cmpport_ctl_regs
    import cmpport_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int LSB = LOW_IMPL
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_req_t     req,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] drv_q
);
    logic wr_mask;
    logic wr_drv;

    assign wr_mask = req.wr && (req.addr == ADR_MASK);
    assign wr_drv  = req.wr && (req.addr == ADR_DRV);

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b >= LSB) begin : g_impl
            always_ff @(posedge clk) begin
                if (rst) begin
                    mask_q[b] <= 1'b0;
                    drv_q[b]  <= 1'b0;
                end else begin
                    if (wr_mask) mask_q[b] <= req.wdata[b];
                    if (wr_drv)  drv_q[b]  <= req.wdata[b];
                end
            end
        end else begin : g_absent
            assign mask_q[b] = 1'b0;
            assign drv_q[b]  = 1'b0;
        end
    end

endmodule

// File: rtl/cmpport_port_reg.sv
module cmpport_port_reg
    import cmpport_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_req_t     req,
    input  logic         cmp_match,
    input  logic [W-1:0] mask_q,
    input  logic [W-1:0] drv_q,
    output logic [W-1:0] port_q
);
    logic [W-1:0] base;
    logic [W-1:0] port_d;
    logic         wr_port;

    assign wr_port = req.wr && (req.addr == ADR_PORT);

    always_comb begin
        base   = wr_port ? req.wdata : port_q;
        port_d = cmp_match ? mask_merge(mask_q, drv_q, base) : base;
    end

    always_ff @(posedge clk) begin
        if (rst) port_q <= '0;
        else     port_q <= port_d;
    end

endmodule

// File: rtl/cmpport_rd_mux.sv
module cmpport_rd_mux
    import cmpport_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_req_t     req,
    input  logic [W-1:0] mask_q,
    input  logic [W-1:0] drv_q,
    input  logic [W-1:0] port_q,
    output logic [W-1:0] rd_q
);
    logic [W-1:0] sel;

    always_comb begin
        unique case (req.addr)
            ADR_MASK: sel = mask_q;
            ADR_DRV:  sel = drv_q;
            ADR_PORT: sel = port_q;
            default:  sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (req.rd) rd_q <= sel;
    end

endmodule

// File: rtl/cmpport_top.sv
module cmpport_top
    import cmpport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cmp_match,
    output logic [DATA_W-1:0] port_out
);
    bus_req_t          req;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] drv_q;
    logic [DATA_W-1:0] port_q;

    assign req.wr    = wr_en;
    assign req.rd    = rd_en;
    assign req.addr  = reg_addr_e'(bus_addr);
    assign req.wdata = wr_data;

    cmpport_ctl_regs #(.W(DATA_W), .LSB(LOW_IMPL)) u_regs (
        .clk(clk), .rst(rst), .req(req), .mask_q(mask_q), .drv_q(drv_q)
    );

    cmpport_port_reg #(.W(DATA_W)) u_port (
        .clk(clk), .rst(rst), .req(req), .cmp_match(cmp_match),
        .mask_q(mask_q), .drv_q(drv_q), .port_q(port_q)
    );

    cmpport_rd_mux #(.W(DATA_W)) u_rd (
        .clk(clk), .rst(rst), .req(req), .mask_q(mask_q), .drv_q(drv_q),
        .port_q(port_q), .rd_q(rd_data)
    );

    assign port_out = port_q;

endmodule

// File: rtl/cmpport_chk.sv
module cmpport_chk
    import cmpport_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              cmp_match,
    input logic [DATA_W-1:0] port_out,
    input logic [DATA_W-1:0] mask_q,
    input logic [DATA_W-1:0] drv_q
);
    logic port_wr;
    assign port_wr = wr_en && (bus_addr == ADR_PORT);

    // R3: masked bits follow drive data after a compare
    a_r3_masked_load: assert property (@(posedge clk) disable iff (rst)
        cmp_match |=> ((port_out & $past(mask_q)) == ($past(drv_q) & $past(mask_q))));

    // R4: unmasked bits hold across a compare without a port write
    a_r4_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
        (cmp_match && !port_wr) |=>
        ((port_out & ~$past(mask_q)) == ($past(port_out) & ~$past(mask_q))));

    // R6: unmasked bits take the written byte when write and compare coincide
    a_r6_cpu_unmasked: assert property (@(posedge clk) disable iff (rst)
        (cmp_match && port_wr) |=>
        ((port_out & ~$past(mask_q)) == ($past(wr_data) & ~$past(mask_q))));

    // R7: port holds with no compare and no port write
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!cmp_match && !port_wr) |=> $stable(port_out));

    // R8: read data holds while the read strobe is low
    a_r8_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

bind cmpport_top cmpport_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .cmp_match(cmp_match), .port_out(port_out),
    .mask_q(mask_q), .drv_q(drv_q)
);

// File: tb/tb_cmpport_top.sv
module tb_cmpport_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       cmp_match = 1'b0;
    logic [7:0] port_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmpport_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cmp_match(cmp_match), .port_out(port_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus/match cycle, driven at negedge, released at the next negedge.
    task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d,
                       input logic r, input logic m);
        @(negedge clk);
        wr_en = w; bus_addr = a; wr_data = d; rd_en = r; cmp_match = m;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; cmp_match = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        cyc(1'b0, a, 8'h00, 1'b1, 1'b0);
        v = rd_data;
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 port", port_out, 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
        rd(2'd0, v); chk("R1 mask", v, 8'h00);
        rd(2'd1, v); chk("R1 drv", v, 8'h00);

        // R2 low bits not implemented
        cyc(1'b1, 2'd0, 8'hFF, 1'b0, 1'b0);
        rd(2'd0, v); chk("R2 mask FF", v, 8'hF8);
        cyc(1'b1, 2'd1, 8'h07, 1'b0, 1'b0);
        rd(2'd1, v); chk("R2 drv 07", v, 8'h00);
        cyc(1'b1, 2'd1, 8'hFF, 1'b0, 1'b0);
        cyc(1'b1, 2'd2, 8'h05, 1'b0, 1'b0);
        cyc(1'b0, 2'd0, 8'h00, 1'b0, 1'b1);
        chk("R2 low bits do not drive port", port_out, 8'hFD);

        // R5 port write, R8 read-back
        cyc(1'b1, 2'd2, 8'h5A, 1'b0, 1'b0);
        chk("R5 port write", port_out, 8'h5A);
        rd(2'd2, v); chk("R8 read port", v, 8'h5A);
        rd(2'd3, v); chk("R8 unused addr", v, 8'h00);
        rd(2'd0, held);
        cyc(1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
        chk("R8 rd_data holds without rd_en", rd_data, held);

        // R7 idle cycles leave port alone
        repeat (4) @(negedge clk);
        chk("R7 idle hold", port_out, 8'h5A);

        // R3/R4 sweep over all implemented mask and data values
        for (int m = 0; m < 32; m++) begin
            for (int d = 0; d < 32; d++) begin
                logic [7:0] mv, dv, pv, ev;
                mv = 8'(m << 3);
                dv = 8'(d << 3);
                pv = 8'((m * 37 + d * 11 + 3) & 255);
                cyc(1'b1, 2'd0, mv | 8'h02, 1'b0, 1'b0);
                cyc(1'b1, 2'd1, dv | 8'h05, 1'b0, 1'b0);
                cyc(1'b1, 2'd2, pv, 1'b0, 1'b0);
                @(negedge clk);
                wr_en = 1'b0; cmp_match = 1'b1;
                @(posedge clk);
                #1;
                ev = (mv & dv) | (~mv & pv);
                chk("R3 R4 R7 compare merge", port_out, ev);
                @(negedge clk);
                cmp_match = 1'b0;
            end
        end

        // R6 coincident port write and compare
        cyc(1'b1, 2'd0, 8'hC8, 1'b0, 1'b0);
        cyc(1'b1, 2'd1, 8'h88, 1'b0, 1'b0);
        cyc(1'b1, 2'd2, 8'h00, 1'b0, 1'b0);
        cyc(1'b1, 2'd2, 8'h37, 1'b0, 1'b1);
        chk("R6 write plus compare", port_out, (8'hC8 & 8'h88) | (~8'hC8 & 8'h37));

        // R9 compare uses mask from before same-edge mask write
        cyc(1'b1, 2'd2, 8'h00, 1'b0, 1'b0);
        cyc(1'b1, 2'd1, 8'hF8, 1'b0, 1'b0);
        cyc(1'b1, 2'd0, 8'h18, 1'b0, 1'b0);
        cyc(1'b1, 2'd0, 8'hE0, 1'b0, 1'b1);
        chk("R9 old mask used", port_out, 8'h18);
        rd(2'd0, v); chk("R9 new mask stored", v, 8'hE0);

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 port after reset", port_out, 8'h00);
        rd(2'd1, v); chk("R1 drv after reset", v, 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule